// File: doc/BRIEF.md
# Sweep Control Sequencer

This block steps a swept measurement instrument through its control phases. It keeps a three-bit phase code and moves it at most one step per clock. Each phase has its own entry condition, built from a small set of status flags. When that condition is not met, the phase code holds. The flags are an in-use flag, a gate enable, an active-low sweep reset, a delay-complete flag, an active-low settle flag and a comparator result. Every flag is assumed to be already synchronous to the clock.

After a clear, the code starts at 000. It passes through 100 once, then runs a six-phase loop: 101, 111, 110, 010, 011, 001, and back to 101. Only one bit of the code flips on each step. Each bit is held in a JK-type flip-flop. Excitation logic sets J and K for each bit from the phase code it is heading for.

The phase code is a plain control output. It has no handshake and no back-pressure, because nothing flows through the block.

Top module: `sweep_sequencer`

## Requirements
- R1: While `clr` is high at a rising clock edge, `state` becomes 000 after that edge, whatever the flag values.
- R2: From 000 the code goes to 100 when (`in_use` and `gate_en` are both 1) or `sweep_rst_n` is 0. Otherwise it stays at 000.
- R3: From 100 the code goes to 101 when `dly_done` is 1 and `sweep_rst_n` is 1. Otherwise it stays at 100.
- R4: From 101 the code goes to 111 when `settle_n` is 1. Otherwise it stays at 101.
- R5: From 111 the code goes to 110 when `cmp` is 1 and `settle_n` is 1. Otherwise it stays at 111.
- R6: From 110 the code goes to 010 when `sweep_rst_n` is 0. Otherwise it stays at 110.
- R7: From 010 the code goes to 011 when `cmp` is 0. Otherwise it stays at 010.
- R8: From 011 the code goes to 001 when `dly_done` is 1. Otherwise it stays at 011.
- R9: From 001 the code goes to 101 when `cmp` is 1. Otherwise it stays at 001.
- R10: Without `clr`, the code changes in at most one bit per edge. Once it is in the loop {101, 111, 110, 010, 011, 001}, it never returns to 000 or 100. Flags that are not named in the condition for the current phase have no effect. `state[2]` is bit C, `state[1]` is bit B and `state[0]` is bit A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, forces code 000 |
| in_use | input | 1 | In-use flag (entry from 000) |
| gate_en | input | 1 | Gate enable flag (entry from 000) |
| sweep_rst_n | input | 1 | Active-low sweep reset qualifier |
| dly_done | input | 1 | Delay complete flag |
| settle_n | input | 1 | Active-low settle/response flag |
| cmp | input | 1 | Comparator result |
| state | output | 3 | Phase code {C,B,A} |

## Verification
The assertions assume the following about the inputs:
- Every flag is a known 0 or 1, and is stable around each rising edge.
- `clr` is raised at least once before any transition property is relied on.

The transition checks are therefore gated by a counter that starts only after the first clear. The stimulus meets these assumptions in two ways. It changes every input one time unit after a rising edge, and it asserts `clr` at the start of the run. It then drives each phase through every flag pattern that should hold, before driving the pattern that advances.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    PH_IDLE   = 3'b000,
    PH_ARM    = 3'b100,
    PH_RUN    = 3'b101,
    PH_SETTLE = 3'b111,
    PH_PEAK   = 3'b110,
    PH_FALL   = 3'b010,
    PH_WAIT   = 3'b011,
    PH_RETURN = 3'b001
  } phase_t;

  typedef struct packed {
    logic in_use;
    logic gate_en;
    logic sweep_rst_n;
    logic dly_done;
    logic settle_n;
    logic cmp;
  } qual_t;
endpackage

// File: rtl/sweep_seq_advance.sv
module sweep_seq_advance
  import sweep_seq_pkg::*;
(
  input  logic [ST_W-1:0] cur,
  input  qual_t           q,
  output logic [ST_W-1:0] tgt,
  output logic            go
);
  always_comb begin
    tgt = cur;
    go  = 1'b0;
    case (phase_t'(cur))
      PH_IDLE: begin
        tgt = PH_ARM;
        go  = (q.in_use & q.gate_en) | ~q.sweep_rst_n;
      end
      PH_ARM: begin
        tgt = PH_RUN;
        go  = q.dly_done & q.sweep_rst_n;
      end
      PH_RUN: begin
        tgt = PH_SETTLE;
        go  = q.settle_n;
      end
      PH_SETTLE: begin
        tgt = PH_PEAK;
        go  = q.cmp & q.settle_n;
      end
      PH_PEAK: begin
        tgt = PH_FALL;
        go  = ~q.sweep_rst_n;
      end
      PH_FALL: begin
        tgt = PH_WAIT;
        go  = ~q.cmp;
      end
      PH_WAIT: begin
        tgt = PH_RETURN;
        go  = q.dly_done;
      end
      PH_RETURN: begin
        tgt = PH_RUN;
        go  = q.cmp;
      end
      default: begin
        tgt = cur;
        go  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sweep_seq_excite.sv
module sweep_seq_excite #(
  parameter int W = 3
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] tgt,
  input  logic         go,
  output logic [W-1:0] j,
  output logic [W-1:0] k
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // rise needs J, fall needs K, any hold leaves both low
    assign j[i] = go & ~cur[i] &  tgt[i];
    assign k[i] = go &  cur[i] & ~tgt[i];
  end
endmodule

// File: rtl/sweep_seq_jkbank.sv
module sweep_seq_jkbank #(
  parameter int          W       = 3,
  parameter logic [W-1:0] CLR_VAL = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_ff
    always_ff @(posedge clk) begin
      if (clr) begin
        q[i] <= CLR_VAL[i];
      end else begin
        case ({j[i], k[i]})
          2'b10:   q[i] <= 1'b1;
          2'b01:   q[i] <= 1'b0;
          2'b11:   q[i] <= ~q[i];
          default: q[i] <= q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import sweep_seq_pkg::*;
(
  input  logic            clk,
  input  logic            clr,
  input  logic            in_use,
  input  logic            gate_en,
  input  logic            sweep_rst_n,
  input  logic            dly_done,
  input  logic            settle_n,
  input  logic            cmp,
  output logic [ST_W-1:0] state
);
  qual_t            quals;
  logic [ST_W-1:0]  tgt;
  logic             go;
  logic [ST_W-1:0]  j_in;
  logic [ST_W-1:0]  k_in;
  logic [ST_W-1:0]  cur;

  assign quals = '{in_use: in_use, gate_en: gate_en, sweep_rst_n: sweep_rst_n,
                   dly_done: dly_done, settle_n: settle_n, cmp: cmp};

  sweep_seq_advance u_adv (
    .cur (cur),
    .q   (quals),
    .tgt (tgt),
    .go  (go)
  );

  sweep_seq_excite #(.W(ST_W)) u_exc (
    .cur (cur),
    .tgt (tgt),
    .go  (go),
    .j   (j_in),
    .k   (k_in)
  );

  sweep_seq_jkbank #(.W(ST_W), .CLR_VAL(PH_IDLE)) u_ff (
    .clk (clk),
    .clr (clr),
    .j   (j_in),
    .k   (k_in),
    .q   (cur)
  );

  assign state = cur;
endmodule

// File: rtl/sweep_sequencer_chk.sv
module sweep_sequencer_chk
  import sweep_seq_pkg::*;
(
  input logic            clk,
  input logic            clr,
  input logic            gate_en,
  input logic            in_use,
  input logic            sweep_rst_n,
  input logic            settle_n,
  input logic            cmp,
  input logic [ST_W-1:0] state
);
  logic [1:0] age = 2'd0;

  always_ff @(posedge clk) begin
    if (clr)                          age <= 2'd1;
    else if (age != 2'd0 && age != 2'd3) age <= age + 2'd1;
  end

  // R1
  clear_to_idle_chk: assert property (@(posedge clk)
    clr |=> (state == 3'b000));

  // R10
  one_bit_step_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    $countones(state ^ $past(state)) <= 1);

  // R10
  no_reentry_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    (state != 3'b000 && state != 3'b100) |=> (state != 3'b000 && state != 3'b100));

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    (state == 3'b101 && !settle_n) |=> (state == 3'b101));

  // R9
  return_dest_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    (state == 3'b001) |=> (state == 3'b001 || state == 3'b101));

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    (state == 3'b000 && ((in_use && gate_en) || !sweep_rst_n)) |=> (state == 3'b100));

  // R7
  fall_hold_chk: assert property (@(posedge clk) disable iff (clr || age < 2'd2)
    (state == 3'b010 && cmp) |=> $stable(state));
endmodule

bind sweep_sequencer sweep_sequencer_chk u_chk (
  .clk         (clk),
  .clr         (clr),
  .gate_en     (gate_en),
  .in_use      (in_use),
  .sweep_rst_n (sweep_rst_n),
  .settle_n    (settle_n),
  .cmp         (cmp),
  .state       (state)
);

// File: tb/sweep_sequencer_bench.sv
`timescale 1ns/1ps
module sweep_sequencer_bench;
  logic       clk = 1'b0;
  logic       clr = 1'b0;
  logic [5:0] qv  = 6'b001010;  // {in_use,gate_en,sweep_rst_n,dly_done,settle_n,cmp}
  logic [2:0] state;
  logic [2:0] exp_st;
  int         n_run  = 0;
  int         n_fail = 0;
  int         cycles = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  sweep_sequencer u_sweep_sequencer (
    .clk(clk), .clr(clr), .in_use(qv[5]), .gate_en(qv[4]),
    .sweep_rst_n(qv[3]), .dly_done(qv[2]), .settle_n(qv[1]), .cmp(qv[0]),
    .state(state)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic [5:0] q);
    bit u = q[5], g = q[4], r = q[3], d = q[2], sn = q[1], c = q[0];
    case (s)
      3'b000: return ((u && g) || !r) ? 3'b100 : s;
      3'b100: return (d && r)         ? 3'b101 : s;
      3'b101: return sn               ? 3'b111 : s;
      3'b111: return (c && sn)        ? 3'b110 : s;
      3'b110: return !r               ? 3'b010 : s;
      3'b010: return !c               ? 3'b011 : s;
      3'b011: return d                ? 3'b001 : s;
      3'b001: return c                ? 3'b101 : s;
      default: return s;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'b000: return "R2";
      3'b100: return "R3";
      3'b101: return "R4";
      3'b111: return "R5";
      3'b110: return "R6";
      3'b010: return "R7";
      3'b011: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: state=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock with flags q; compare state against model after the edge
  task automatic cyc(input logic [5:0] q);
    logic [2:0] prev;
    string      rq;
    qv   = q;
    prev = exp_st;
    rq   = req_of(exp_st);
    exp_st = clr ? 3'b000 : ref_next(exp_st, q);
    @(posedge clk);
    #1;
    cycles++;
    if (clr) check(state === exp_st, "R1", state, exp_st);
    else begin
      check(state === exp_st, rq, state, exp_st);
      // R10 single bit step and no reentry into entry phases
      check($countones(state ^ prev) <= 1, "R10", state, exp_st);
      if (prev != 3'b000 && prev != 3'b100)
        check(state != 3'b000 && state != 3'b100, "R10", state, exp_st);
    end
  endtask

  initial begin
    exp_st = 3'b000;
    @(posedge clk); #1;
    // R1 clear from unknown power-on value, flags that would advance
    clr = 1'b1;
    cyc(6'b110111);
    cyc(6'b111111);
    clr = 1'b0;
    // two laps: every holding pattern first, then the advancing one
    for (int lap = 0; lap < 2; lap++) begin
      for (int st = 0; st < 8; st++) begin
        logic [5:0] adv = 6'b000000;
        for (int p = 0; p < 64; p++) begin
          if (ref_next(exp_st, 6'(p)) == exp_st) cyc(6'(p));
          else adv = 6'(p);
        end
        if (exp_st == 3'b000 && lap == 1) break;
        cyc(adv);
        if (lap == 1 && st == 1) begin
          // R1 clear mid-loop overrides advancing flags
          clr = 1'b1;
          cyc(6'b111111);
          clr = 1'b0;
          break;
        end
      end
    end
    // pseudo-random flags over a long stretch, R10 and per-phase rules
    begin
      logic [31:0] lfsr = 32'hACE1_1234;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        clr  = (lfsr[15:8] == 8'h5A);
        cyc(lfsr[5:0]);
      end
      clr = 1'b0;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: state=%b expected=%b", state, exp_st);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule